// File: doc/BRIEF.md
# Aperture Translation Cache with Enable Control

This block keeps a small, fully associative set of page translations for a graphics aperture. Incoming aperture requests carry a page number. If the cache is enabled and holds that page, the stored translation is returned at once. Otherwise the block issues a fetch of the translation table entry on a memory port and waits for the reply. The reply is returned to the requester and, depending on the mode, written into the cache. Replacement is true least-recently-used, tracked with one age counter per way.

A 32-bit control register turns the cache on and off. When the enable bit is cleared, every way is invalidated and lookups go straight to memory. In that disabled mode a fetched entry whose own valid flag is set is not stored. A fetched entry whose valid flag is clear is still stored, and it displaces the least recently used way. A register write that flips the enable bit raises a drain request to a separate posted-write buffer. The write is not acknowledged until that buffer reports it is done, and the new setting takes effect only at that point. A second control bit forces a 3-bit rate field to read as 001.

The request, response, fetch and fill paths are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. A source holds valid and its payload unchanged until the transfer. The block accepts a new request only when it is idle, and it holds a response for as long as `rsp_ready` stays low. Register and drain signals are plain pulses and levels.

Top module: `apt_xlate_cache`

## Requirements
- R1: After reset, the control register at offset 0xB0 reads 0x00000000, the cache is disabled and holds no entries, and `rate_out` equals `rate_in`.
- R2: Within the control register, bit 7 is the enable bit and bit 0 is the rate override bit. All other bits read as 0 and ignore writes. A read of any other offset returns 0, and a write to any other offset changes nothing and is still acknowledged.
- R3: A write to 0xB0 that changes bit 7 raises `drain_req` in the following cycle. `drain_req` stays high and `reg_ack` stays low until `drain_done` is sampled high. On that edge the new enable and override values take effect, `reg_ack` pulses for one cycle and `drain_req` drops.
- R4: A write to 0xB0 that leaves bit 7 unchanged never raises `drain_req`, updates bit 0, and pulses `reg_ack` in the cycle after the write. A read pulses `reg_ack` with `reg_rdata` in the cycle after the read strobe.
- R5: Clearing the enable bit invalidates every way on the same edge that the bit clears. A flush takes precedence over a fill on that edge. A page cached before the flush misses after the cache is enabled again.
- R6: While the cache is disabled, every request fetches its entry from memory, even for a page that is held in the cache.
- R7: While the cache is disabled, a fill with `fill_ok`=1 is returned to the requester but is not stored.
- R8: While the cache is disabled, a fill with `fill_ok`=0 is stored. After the cache is enabled, a request for that page hits and returns `rsp_ok`=0 with the stored page and without a fetch.
- R9: While the cache is enabled, a hit returns the cached translation with `rsp_valid` two cycles after the request is accepted and with no fetch. A miss raises `fetch_valid` two cycles after acceptance and stores the fill.
- R10: A fill into a full cache replaces the least recently used way. Both hits and fills count as uses, and the ages of the ways always form a permutation of 0..WAYS-1.
- R11: While bit 0 is set, `rate_out` reads 001. Otherwise `rate_out` follows `rate_in`.
- R12: `req_ready` is high only while idle. `fetch_valid` with `fetch_page` holds until `fetch_ready`. `rsp_valid`, `rsp_page` and `rsp_ok` hold until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_page | input | 20 | Aperture page to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes response |
| rsp_page | output | 20 | Translated page |
| rsp_ok | output | 1 | Valid flag of the translation entry |
| fetch_valid | output | 1 | Table entry fetch request |
| fetch_ready | input | 1 | Memory accepts fetch |
| fetch_page | output | 20 | Page whose entry is fetched |
| fill_valid | input | 1 | Fetched entry returned |
| fill_ready | output | 1 | Block waiting for a fill |
| fill_page | input | 20 | Fetched translated page |
| fill_ok | input | 1 | Valid flag of the fetched entry |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_ack |
| reg_ack | output | 1 | One-cycle access completion |
| drain_req | output | 1 | Ask write buffer to flush dirty entries |
| drain_done | input | 1 | Write buffer drained |
| rate_in | input | 3 | Native rate field |
| rate_out | output | 3 | Rate field as reported |

## Verification
Each result has a fixed cycle, counted from the edge that accepts a request or strobe. A hit response appears after two edges. A miss shows `fetch_valid` after two edges, and its response appears two edges after the fetch handshake. A read or a non-toggling write acknowledges after one edge. A toggling write acknowledges one edge after `drain_done` is sampled, and `reg_ack` is checked to stay low on every cycle before that. The bench drives inputs and samples outputs at the falling edge, counts edges as it goes, and compares each observation against the exact cycle due. A late or early result is therefore a miscompare, as is a fetch where a hit was expected.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned OVR_BIT  = 0;
  localparam logic [2:0]  RATE_FORCED = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xl_state_e;
endpackage

// File: rtl/apt_ctrl_reg.sv
module apt_ctrl_reg
  import apt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              reg_ack,
  output logic              drain_req,
  input  logic              drain_done,
  output logic              en,
  output logic              ovr,
  output logic              flush
);
  logic busy, pend_en, pend_ovr;
  logic sel;

  assign sel       = (reg_addr == CTRL_ADDR);
  assign drain_req = busy;
  // invalidate on the very edge the enable bit drops
  assign flush     = busy && drain_done && en && !pend_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend_en   <= 1'b0;
      pend_ovr  <= 1'b0;
      en        <= 1'b0;
      ovr       <= 1'b0;
      reg_ack   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack <= 1'b0;
      if (busy) begin
        if (drain_done) begin
          en      <= pend_en;
          ovr     <= pend_ovr;
          busy    <= 1'b0;
          reg_ack <= 1'b1;
        end
      end else if (reg_wr) begin
        if (sel && (reg_wdata[EN_BIT] != en)) begin
          busy     <= 1'b1;
          pend_en  <= reg_wdata[EN_BIT];
          pend_ovr <= reg_wdata[OVR_BIT];
        end else begin
          if (sel) ovr <= reg_wdata[OVR_BIT];
          reg_ack <= 1'b1;
        end
      end else if (reg_rd) begin
        reg_ack   <= 1'b1;
        reg_rdata <= '0;
        if (sel) begin
          reg_rdata[EN_BIT]  <= en;
          reg_rdata[OVR_BIT] <= ovr;
        end
      end
    end
  end
endmodule

// File: rtl/apt_tag_store.sv
module apt_tag_store #(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned PAGE_W = 20,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr,
  input  logic [IDX_W-1:0]  wr_way,
  input  logic [PAGE_W-1:0] wr_tag,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_ok,
  input  logic [PAGE_W-1:0] lk_tag,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_way,
  output logic [PAGE_W-1:0] hit_page,
  output logic              hit_ok,
  output logic [WAYS-1:0]   valid_vec
);
  logic [PAGE_W-1:0] tag_q  [WAYS];
  logic [PAGE_W-1:0] page_q [WAYS];
  logic [WAYS-1:0]   ok_q;
  logic [WAYS-1:0]   match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[w] <= 1'b0;
        tag_q[w]     <= '0;
        page_q[w]    <= '0;
        ok_q[w]      <= 1'b0;
      end else if (flush) begin
        valid_vec[w] <= 1'b0;
      end else if (wr && (wr_way == IDX_W'(w))) begin
        valid_vec[w] <= 1'b1;
        tag_q[w]     <= wr_tag;
        page_q[w]    <= wr_page;
        ok_q[w]      <= wr_ok;
      end
    end
    assign match[w] = valid_vec[w] && (tag_q[w] == lk_tag);
  end

  always_comb begin
    hit      = |match;
    hit_way  = '0;
    hit_page = '0;
    hit_ok   = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_way  = IDX_W'(i);
        hit_page = page_q[i];
        hit_ok   = ok_q[i];
      end
    end
  end
endmodule

// File: rtl/apt_lru.sv
module apt_lru #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  touch,
  input  logic [IDX_W-1:0]      touch_way,
  input  logic [WAYS-1:0]       valid_vec,
  output logic [IDX_W-1:0]      victim,
  output logic [WAYS*IDX_W-1:0] ages_flat
);
  logic [IDX_W-1:0] age [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign ages_flat[w*IDX_W +: IDX_W] = age[w];
    always_ff @(posedge clk) begin
      if (!rst_n)
        age[w] <= IDX_W'(w);
      else if (touch) begin
        if (touch_way == IDX_W'(w))
          age[w] <= '0;
        else if (age[w] < age[touch_way])
          age[w] <= age[w] + 1'b1;
      end
    end
  end

  // lowest empty way first, otherwise the oldest way
  always_comb begin
    victim = '0;
    for (int i = 0; i < WAYS; i++)
      if (age[i] == IDX_W'(WAYS - 1)) victim = IDX_W'(i);
    for (int i = WAYS - 1; i >= 0; i--)
      if (!valid_vec[i]) victim = IDX_W'(i);
  end
endmodule

// File: rtl/apt_xlate_cache.sv
module apt_xlate_cache
  import apt_pkg::*;
#(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned PAGE_W = 20,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PAGE_W-1:0] req_page,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PAGE_W-1:0] rsp_page,
  output logic              rsp_ok,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [PAGE_W-1:0] fetch_page,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [PAGE_W-1:0] fill_page,
  input  logic              fill_ok,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              reg_ack,
  output logic              drain_req,
  input  logic              drain_done,
  input  logic [RATE_W-1:0] rate_in,
  output logic [RATE_W-1:0] rate_out
);
  localparam int unsigned IDX_W = $clog2(WAYS);

  xl_state_e state;
  logic [PAGE_W-1:0] cur_page, rsp_page_q;
  logic rsp_ok_q;
  logic en, ovr, flush;
  logic hit, hit_ok;
  logic [IDX_W-1:0] hit_way, victim, touch_way, fill_way;
  logic [PAGE_W-1:0] hit_page;
  logic [WAYS-1:0] valid_vec;
  logic [WAYS*IDX_W-1:0] ages_flat;
  logic install, touch, look_hit;

  apt_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ack(reg_ack), .drain_req(drain_req), .drain_done(drain_done),
    .en(en), .ovr(ovr), .flush(flush)
  );

  apt_tag_store #(.WAYS(WAYS), .PAGE_W(PAGE_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr(install), .wr_way(fill_way),
    .wr_tag(cur_page), .wr_page(fill_page), .wr_ok(fill_ok), .lk_tag(cur_page),
    .hit(hit), .hit_way(hit_way), .hit_page(hit_page), .hit_ok(hit_ok),
    .valid_vec(valid_vec)
  );

  apt_lru #(.WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_way(touch_way),
    .valid_vec(valid_vec), .victim(victim), .ages_flat(ages_flat)
  );

  assign look_hit  = (state == ST_LOOK) && en && hit;
  // disabled: only entries flagged invalid are kept; a flush wins
  assign install   = (state == ST_WAIT) && fill_valid && (en || !fill_ok) && !flush;
  assign fill_way  = hit ? hit_way : victim;
  assign touch     = look_hit || install;
  assign touch_way = look_hit ? hit_way : fill_way;

  assign req_ready   = (state == ST_IDLE);
  assign fetch_valid = (state == ST_FETCH);
  assign fetch_page  = cur_page;
  assign fill_ready  = (state == ST_WAIT);
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_page    = rsp_page_q;
  assign rsp_ok      = rsp_ok_q;
  assign rate_out    = ovr ? RATE_W'(RATE_FORCED) : rate_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_page   <= '0;
      rsp_page_q <= '0;
      rsp_ok_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (req_valid) begin
                    cur_page <= req_page;
                    state    <= ST_LOOK;
                  end
        ST_LOOK:  if (look_hit) begin
                    rsp_page_q <= hit_page;
                    rsp_ok_q   <= hit_ok;
                    state      <= ST_RESP;
                  end else begin
                    state <= ST_FETCH;
                  end
        ST_FETCH: if (fetch_ready) state <= ST_WAIT;
        ST_WAIT:  if (fill_valid) begin
                    rsp_page_q <= fill_page;
                    rsp_ok_q   <= fill_ok;
                    state      <= ST_RESP;
                  end
        ST_RESP:  if (rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/apt_xlate_checker.sv
module apt_xlate_checker #(
  parameter int unsigned WAYS   = 8,
  parameter int unsigned PAGE_W = 20,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  en,
  input logic [WAYS-1:0]       valid_vec,
  input logic [WAYS*IDX_W-1:0] ages_flat,
  input logic                  fetch_valid,
  input logic                  fetch_ready,
  input logic [PAGE_W-1:0]     fetch_page,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [PAGE_W-1:0]     rsp_page,
  input logic                  rsp_ok,
  input logic                  drain_req,
  input logic                  drain_done,
  input logic                  reg_ack
);
  logic [WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int i = 0; i < WAYS; i++)
      age_seen[ages_flat[i*IDX_W +: IDX_W]] = 1'b1;
  end

  p_drain_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req && !drain_done |=> !reg_ack);

  p_flush_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> (valid_vec == '0));

  p_age_perm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(age_seen) == WAYS);

  p_fetch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_page));

  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_page) && $stable(rsp_ok));
endmodule

bind apt_xlate_cache apt_xlate_checker #(.WAYS(WAYS), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .valid_vec(valid_vec), .ages_flat(ages_flat),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_page(fetch_page),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_page(rsp_page), .rsp_ok(rsp_ok),
  .drain_req(drain_req), .drain_done(drain_done), .reg_ack(reg_ack)
);

// File: tb/sim_apt_xlate_cache.sv
module sim_apt_xlate_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 0, fetch_ready = 0, fill_valid = 0, fill_ok = 0;
  logic reg_wr = 0, reg_rd = 0, drain_done = 0;
  logic [19:0] req_page = '0, fill_page = '0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  rate_in = 3'b100;
  logic req_ready, rsp_valid, rsp_ok, fetch_valid, fill_ready, reg_ack, drain_req;
  logic [19:0] rsp_page, fetch_page;
  logic [31:0] reg_rdata;
  logic [2:0]  rate_out;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  apt_xlate_cache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_page(rsp_page), .rsp_ok(rsp_ok), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_page(fetch_page), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_page(fill_page), .fill_ok(fill_ok),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack), .drain_req(drain_req),
    .drain_done(drain_done), .rate_in(rate_in), .rate_out(rate_out)
  );

  function automatic logic [19:0] xl(input logic [19:0] p);
    return p + 20'h4_0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d,
                           input bit drains, input string rq);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (drains) begin
      chk(drain_req && !reg_ack, rq, "drain raised, ack held", {drain_req, reg_ack}, 2'b10);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(drain_req && !reg_ack, rq, "stall while draining", {drain_req, reg_ack}, 2'b10);
      end
      drain_done = 1;
      @(negedge clk); drain_done = 0;
      chk(reg_ack && !drain_req, rq, "ack after drain", {drain_req, reg_ack}, 2'b01);
    end else begin
      chk(reg_ack && !drain_req, rq, "ack without drain", {drain_req, reg_ack}, 2'b01);
    end
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string rq);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    chk(reg_ack, rq, "read ack", reg_ack, 1);
    chk(reg_rdata == exp, rq, "read data", reg_rdata, exp);
  endtask

  // one request; memory answers any fetch with (tr, ok); hold = rsp back-pressure cycles
  task automatic access(input logic [19:0] pg, input bit exp_hit, input logic [19:0] tr,
                        input bit ok, input logic [19:0] exp_pg, input bit exp_ok,
                        input int hold, input string rq);
    int cyc = 0, fcyc = -1, rcyc = -1;
    bit done = 0;
    @(negedge clk);
    chk(req_ready, "R12", "idle ready", req_ready, 1);
    req_valid = 1; req_page = pg;
    @(negedge clk); req_valid = 0; cyc = 1;
    while (!done && cyc < 40) begin
      if (fetch_valid) begin
        fcyc = cyc;
        chk(fetch_page == pg, rq, "fetch page", fetch_page, pg);
        chk(!req_ready, "R12", "busy not ready", req_ready, 0);
        @(negedge clk); cyc++;
        chk(fetch_valid && fetch_page == pg, "R12", "fetch held", fetch_page, pg);
        fetch_ready = 1;
        @(negedge clk); fetch_ready = 0; cyc++;
        fill_valid = 1; fill_page = tr; fill_ok = ok;
        @(negedge clk); fill_valid = 0; cyc++;
      end else if (rsp_valid) begin
        rcyc = cyc;
        for (int k = 0; k < hold; k++) begin
          @(negedge clk);
          chk(rsp_valid && rsp_page == exp_pg, "R12", "rsp held", rsp_page, exp_pg);
        end
        chk(rsp_page == exp_pg, rq, "rsp page", rsp_page, exp_pg);
        chk(rsp_ok == exp_ok, rq, "rsp ok", rsp_ok, exp_ok);
        rsp_ready = 1;
        @(negedge clk); rsp_ready = 0; done = 1;
      end else begin
        @(negedge clk); cyc++;
      end
    end
    if (exp_hit)
      chk(fcyc < 0 && rcyc == 2, rq, "hit: no fetch, rsp at cycle 2", rcyc, 2);
    else
      chk(fcyc == 2 && rcyc == 5, rq, "miss: fetch at 2, rsp at 5", {fcyc[15:0], rcyc[15:0]}, {16'd2, 16'd5});
  endtask

  task automatic t_reset;
    reg_read(8'hB0, 32'h0, "R1");
    chk(rate_out == rate_in, "R1", "rate after reset", rate_out, rate_in);
  endtask

  task automatic t_fields;
    reg_write(8'hB0, 32'hFFFF_FF7F, 0, "R4");
    reg_read(8'hB0, 32'h0000_0001, "R2");
    chk(rate_out == 3'b001, "R11", "rate forced", rate_out, 3'b001);
    reg_write(8'h10, 32'hFFFF_FFFF, 0, "R2");
    reg_read(8'h10, 32'h0, "R2");
    reg_read(8'hB0, 32'h0000_0001, "R2");
    reg_write(8'hB0, 32'h0, 0, "R4");
    chk(rate_out == rate_in, "R11", "rate native", rate_out, rate_in);
  endtask

  task automatic t_disabled;
    access(20'h00100, 0, xl(20'h00100), 1, xl(20'h00100), 1, 0, "R6");
    access(20'h00100, 0, xl(20'h00100), 1, xl(20'h00100), 1, 2, "R6");
    access(20'h00200, 0, 20'h0_0BAD, 0, 20'h0_0BAD, 0, 0, "R8");
    access(20'h00200, 0, 20'h0_0BAD, 0, 20'h0_0BAD, 0, 0, "R6");
  endtask

  task automatic t_enable;
    reg_write(8'hB0, 32'h80, 1, "R3");
    reg_read(8'hB0, 32'h80, "R3");
    access(20'h00200, 1, 20'h0, 1, 20'h0_0BAD, 0, 0, "R8");
    access(20'h00100, 0, xl(20'h00100), 1, xl(20'h00100), 1, 0, "R7");
    access(20'h00100, 1, 20'h0, 1, xl(20'h00100), 1, 3, "R9");
  endtask

  task automatic t_lru;
    for (int i = 1; i <= 6; i++)
      access(20'h00300 + 20'(i), 0, xl(20'h00300 + 20'(i)), 1, xl(20'h00300 + 20'(i)), 1, 0, "R9");
    access(20'h00200, 1, 20'h0, 1, 20'h0_0BAD, 0, 0, "R10");
    access(20'h00400, 0, xl(20'h00400), 1, xl(20'h00400), 1, 0, "R10");
    access(20'h00200, 1, 20'h0, 1, 20'h0_0BAD, 0, 0, "R10");
    access(20'h00100, 0, xl(20'h00100), 1, xl(20'h00100), 1, 0, "R10");
    access(20'h00302, 1, 20'h0, 1, xl(20'h00302), 1, 0, "R10");
    access(20'h00400, 1, 20'h0, 1, xl(20'h00400), 1, 0, "R10");
  endtask

  task automatic t_flush;
    reg_write(8'hB0, 32'h00, 1, "R3");
    access(20'h00302, 0, xl(20'h00302), 1, xl(20'h00302), 1, 0, "R6");
    reg_write(8'hB0, 32'h80, 1, "R5");
    access(20'h00302, 0, xl(20'h00302), 1, xl(20'h00302), 1, 0, "R5");
    access(20'h00200, 0, 20'h0_0BAD, 0, 20'h0_0BAD, 0, 0, "R5");
  endtask

  task automatic t_same_bit;
    reg_write(8'hB0, 32'h81, 0, "R4");
    reg_read(8'hB0, 32'h81, "R4");
    chk(rate_out == 3'b001, "R11", "rate forced while enabled", rate_out, 3'b001);
    access(20'h00302, 1, 20'h0, 1, xl(20'h00302), 1, 0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_fields;
    t_disabled;
    t_enable;
    t_lru;
    t_flush;
    t_same_bit;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule